// File: doc/BRIEF.md
# Open-Row Bank Scheduler

This block sits behind a first-come-first-served request queue and in front of a set of memory banks. It looks only at the request at the head of the queue and splits its address into column, bank and row fields. It issues the request once the target bank is idle. For each bank it keeps the row that was opened last and a countdown of the cycles until that bank is free again.

On issue the block decides whether the access is a row-buffer hit, meaning that the bank already holds the requested row, or a miss. It then loads the bank's countdown with a short or a long service time, records the new open row, and pulses a one-cycle dequeue to the queue. When a bank's countdown runs out, that bank raises a one-cycle completion pulse. If the head request targets a busy bank, everything waits. No younger request is allowed to overtake it, even when another bank is idle.

The address layout, from the most significant bits down, is row, bank, column, line offset. Rank and channel take no bits because there is a single one of each. The default geometry is a 27-bit address with 2 banks, 16K rows, 64 columns and 64-byte lines. The default service times are 40 cycles for a hit and 200 cycles for a miss.

Top module: `open_row_sched`

## Requirements
- R1: The address is decoded as line offset = bits [5:0] (ignored), column = bits [11:6], bank = bit [12], row = bits [26:13]. The issue outputs report the bank, row and column of the issued request.
- R2: Requests are issued in arrival order. `head_pop` is a one-cycle pulse in the same cycle as `issue_valid`, and two pops are always separated by at least one cycle without a pop.
- R3: While the head request's bank is busy, nothing is issued, even if another bank is idle.
- R4: A request presented at the head to an idle bank, with no pop in that cycle, appears on `issue_valid` in the next cycle.
- R5: `issue_hit` is 1 exactly when the target bank holds a valid open row equal to the request row, and 0 otherwise.
- R6: `bank_done[b]` pulses exactly HIT_CYC cycles after the issue cycle on a hit, and MISS_CYC cycles after it on a miss. `bank_busy[b]` is 1 from the issue cycle up to the cycle before that pulse.
- R7: Every issue replaces the target bank's open row with the request row, so later hit decisions compare against the most recent row.
- R8: After reset no bank holds a valid open row, so the first access to each bank is a miss. `issue_valid`, `head_pop`, `bank_done` and `bank_busy` are all 0.
- R9: A bank accepts its next request no earlier than the cycle after its completion pulse, so the next issue to that bank appears one cycle after that pulse at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_valid | input | 1 | Queue head holds a request |
| head_addr | input | ADDR_W | Address of the head request |
| head_pop | output | 1 | One-cycle dequeue of the head entry |
| issue_valid | output | 1 | A request was issued this cycle |
| issue_bank | output | BANK_W | Bank of the issued request |
| issue_row | output | ROW_W | Row of the issued request |
| issue_col | output | COL_W | Column of the issued request |
| issue_hit | output | 1 | 1 = row hit, 0 = row miss |
| bank_done | output | 2**BANK_W | Per-bank completion pulse |
| bank_busy | output | 2**BANK_W | Per-bank busy indication |

## Verification
The hardest situation to reach is a head request stalled behind its own busy bank while the other bank sits idle and a younger request for it waits in the queue. Random traffic rarely lines up that pattern at a known moment. A directed sequence therefore queues two requests to one bank followed by one to the other bank, and checks the exact issue cycle of the third request. Hits are also hard to get from random traffic, so the random phase draws rows from a tiny set. The directed cases cover the all-ones row and row changes, and each phase starts from reset so that the first-access-is-a-miss rule is exercised again.

// File: rtl/orsched_pkg.sv
package orsched_pkg;

  typedef enum logic {
    ACC_MISS = 1'b0,
    ACC_HIT  = 1'b1
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic row_known, input logic row_same);
    return (row_known && row_same) ? ACC_HIT : ACC_MISS;
  endfunction

endpackage

// File: rtl/orsched_decode.sv
module orsched_decode #(
  parameter int ADDR_W = 27,
  parameter int OFF_W  = 6,
  parameter int COL_W  = 6,
  parameter int BANK_W = 1,
  parameter int ROW_W  = ADDR_W - OFF_W - COL_W - BANK_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [COL_W-1:0]  col,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row
);
  localparam int COL_LSB  = OFF_W;
  localparam int BANK_LSB = OFF_W + COL_W;
  localparam int ROW_LSB  = BANK_LSB + BANK_W;

  always_comb begin
    col  = addr[COL_LSB  +: COL_W];
    bank = addr[BANK_LSB +: BANK_W];
    row  = addr[ROW_LSB  +: ROW_W];
  end
endmodule

// File: rtl/orsched_bank.sv
module orsched_bank #(
  parameter int ROW_W = 14,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ROW_W-1:0] start_row,
  input  logic [CNT_W-1:0] start_lat,
  output logic             open_vld,
  output logic [ROW_W-1:0] open_row,
  output logic             idle,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      open_vld <= 1'b0;
      open_row <= '0;
      done     <= 1'b0;
    end else begin
      done <= (cnt == ONE) && !start;
      if (start) begin
        cnt      <= start_lat;
        open_row <= start_row;
        open_vld <= 1'b1;
      end else if (cnt != '0) begin
        cnt <= cnt - ONE;
      end
    end
  end

  assign idle = (cnt == '0);

  p_start_idle_r4: assert property (@(posedge clk) disable iff (rst)
    start |-> (cnt == '0));
  p_busy_after_start_r6: assert property (@(posedge clk) disable iff (rst)
    start |=> !idle);
  p_done_end_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(cnt) == ONE));
  p_row_kept_r7: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(open_row));
endmodule

// File: rtl/orsched_issue.sv
module orsched_issue
  import orsched_pkg::*;
#(
  parameter int BANK_W   = 1,
  parameter int ROW_W    = 14,
  parameter int COL_W    = 6,
  parameter int CNT_W    = 8,
  parameter int HIT_CYC  = 40,
  parameter int MISS_CYC = 200,
  parameter int NB       = 1 << BANK_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      head_valid,
  input  logic [BANK_W-1:0]         head_bank,
  input  logic [ROW_W-1:0]          head_row,
  input  logic [COL_W-1:0]          head_col,
  input  logic [NB-1:0]             bank_vld,
  input  logic [NB-1:0][ROW_W-1:0]  bank_row,
  input  logic [NB-1:0]             bank_idle,
  output logic [NB-1:0]             bank_start,
  output logic [CNT_W-1:0]          start_lat,
  output logic                      head_pop,
  output logic                      issue_valid,
  output logic [BANK_W-1:0]         issue_bank,
  output logic [ROW_W-1:0]          issue_row,
  output logic [COL_W-1:0]          issue_col,
  output logic                      issue_hit
);
  logic      can_issue;
  acc_kind_e kind;

  always_comb begin
    kind      = classify(bank_vld[head_bank], bank_row[head_bank] == head_row);
    can_issue = head_valid && !head_pop && bank_idle[head_bank];
    start_lat = (kind == ACC_HIT) ? CNT_W'(HIT_CYC) : CNT_W'(MISS_CYC);
  end

  for (genvar b = 0; b < NB; b++) begin : g_start
    assign bank_start[b] = can_issue && (head_bank == BANK_W'(b));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_pop    <= 1'b0;
      issue_valid <= 1'b0;
      issue_bank  <= '0;
      issue_row   <= '0;
      issue_col   <= '0;
      issue_hit   <= 1'b0;
    end else begin
      head_pop    <= can_issue;
      issue_valid <= can_issue;
      if (can_issue) begin
        issue_bank <= head_bank;
        issue_row  <= head_row;
        issue_col  <= head_col;
        issue_hit  <= (kind == ACC_HIT);
      end
    end
  end

  p_pop_gap_r2: assert property (@(posedge clk) disable iff (rst)
    head_pop |=> !head_pop);
  p_single_start_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_start));
  p_hold_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (head_valid && !bank_idle[head_bank]) |=> !issue_valid);
endmodule

// File: rtl/open_row_sched.sv
module open_row_sched #(
  parameter int ADDR_W   = 27,
  parameter int OFF_W    = 6,
  parameter int COL_W    = 6,
  parameter int BANK_W   = 1,
  parameter int HIT_CYC  = 40,
  parameter int MISS_CYC = 200,
  parameter int ROW_W    = ADDR_W - OFF_W - COL_W - BANK_W,
  parameter int NB       = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_valid,
  input  logic [ADDR_W-1:0] head_addr,
  output logic              head_pop,
  output logic              issue_valid,
  output logic [BANK_W-1:0] issue_bank,
  output logic [ROW_W-1:0]  issue_row,
  output logic [COL_W-1:0]  issue_col,
  output logic              issue_hit,
  output logic [NB-1:0]     bank_done,
  output logic [NB-1:0]     bank_busy
);
  localparam int LAT_MAX = (MISS_CYC > HIT_CYC) ? MISS_CYC : HIT_CYC;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  logic [COL_W-1:0]          d_col;
  logic [BANK_W-1:0]         d_bank;
  logic [ROW_W-1:0]          d_row;
  logic [NB-1:0]             b_vld;
  logic [NB-1:0][ROW_W-1:0]  b_row;
  logic [NB-1:0]             b_idle;
  logic [NB-1:0]             b_start;
  logic [CNT_W-1:0]          s_lat;

  orsched_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) i_decode (
    .addr(head_addr), .col(d_col), .bank(d_bank), .row(d_row)
  );

  orsched_issue #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W),
    .HIT_CYC(HIT_CYC), .MISS_CYC(MISS_CYC), .NB(NB)
  ) i_issue (
    .clk(clk), .rst(rst),
    .head_valid(head_valid), .head_bank(d_bank), .head_row(d_row), .head_col(d_col),
    .bank_vld(b_vld), .bank_row(b_row), .bank_idle(b_idle),
    .bank_start(b_start), .start_lat(s_lat),
    .head_pop(head_pop), .issue_valid(issue_valid), .issue_bank(issue_bank),
    .issue_row(issue_row), .issue_col(issue_col), .issue_hit(issue_hit)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    orsched_bank #(.ROW_W(ROW_W), .CNT_W(CNT_W)) i_bank (
      .clk(clk), .rst(rst),
      .start(b_start[b]), .start_row(d_row), .start_lat(s_lat),
      .open_vld(b_vld[b]), .open_row(b_row[b]),
      .idle(b_idle[b]), .done(bank_done[b])
    );
    assign bank_busy[b] = !b_idle[b];
  end

  p_pop_with_issue_r2: assert property (@(posedge clk) disable iff (rst)
    head_pop == issue_valid);
  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (bank_done & bank_busy) == '0);
endmodule

// File: tb/test_open_row_sched.sv
module test_open_row_sched;
  localparam int ADDR_W = 27;
  localparam int HIT    = 5;
  localparam int MISS   = 12;
  localparam int NQ     = 200;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              head_valid = 1'b0;
  logic [ADDR_W-1:0] head_addr = '0;
  logic              head_pop, issue_valid, issue_hit;
  logic [0:0]        issue_bank;
  logic [13:0]       issue_row;
  logic [5:0]        issue_col;
  logic [1:0]        bank_done, bank_busy;

  open_row_sched #(.ADDR_W(ADDR_W), .HIT_CYC(HIT), .MISS_CYC(MISS)) i_open_row_sched (
    .clk(clk), .rst(rst), .head_valid(head_valid), .head_addr(head_addr),
    .head_pop(head_pop), .issue_valid(issue_valid), .issue_bank(issue_bank),
    .issue_row(issue_row), .issue_col(issue_col), .issue_hit(issue_hit),
    .bank_done(bank_done), .bank_busy(bank_busy)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [ADDR_W-1:0] q [NQ];
  int nq;
  logic        m_vld [2];
  logic [13:0] m_row [2];
  int          pend_at [2];
  logic        pend_v [2];
  int          ready [2];

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int row, input int bank, input int col, input int off);
    return {14'(row), 1'(bank), 6'(col), 6'(off)};
  endfunction

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic do_reset();
    rst = 1'b1; head_valid = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk(issue_valid == 1'b0, "R8 issue_valid after reset", int'(issue_valid), 0);
    chk(head_pop == 1'b0, "R8 head_pop after reset", int'(head_pop), 0);
    chk(bank_done == 2'b00, "R8 bank_done after reset", int'(bank_done), 0);
    chk(bank_busy == 2'b00, "R8 bank_busy after reset", int'(bank_busy), 0);
    for (int b = 0; b < 2; b++) begin
      m_vld[b] = 1'b0; m_row[b] = '0; pend_v[b] = 1'b0; pend_at[b] = 0; ready[b] = 0;
    end
  endtask

  task automatic run_phase(input string name);
    int idx = 0, eidx = 0, start, last_iss = -10, limit;
    logic [ADDR_W-1:0] a;
    int b, lat, expc;
    logic [13:0] r;
    logic ehit, busy_x, done_x, finished;
    head_addr = q[0]; head_valid = (nq > 0);
    start = cyc;
    limit = cyc + 20000;
    finished = 1'b0;
    while (!finished) begin
      step();
      if (cyc > limit) begin
        chk(1'b0, {"watchdog ", name}, eidx, nq);
        break;
      end
      chk(head_pop == issue_valid, "R2 head_pop with issue_valid", int'(head_pop), int'(issue_valid));
      if (issue_valid) begin
        if (eidx >= nq) begin
          chk(1'b0, "R2 unexpected issue", eidx, nq);
        end else begin
          a = q[eidx]; b = int'(a[12]); r = a[26:13];
          chk(issue_bank == a[12], "R1 issue_bank", int'(issue_bank), b);
          chk(issue_row == r, "R1 issue_row", int'(issue_row), int'(r));
          chk(issue_col == a[11:6], "R1 issue_col", int'(issue_col), int'(a[11:6]));
          ehit = m_vld[b] && (m_row[b] == r);
          chk(issue_hit == ehit, "R5 R7 R8 issue_hit", int'(issue_hit), int'(ehit));
          expc = last_iss + 2;
          if (ready[b] > expc) expc = ready[b];
          if (start + 1 > expc) expc = start + 1;
          chk(cyc == expc, "R3 R4 R9 issue cycle", cyc, expc);
          lat = ehit ? HIT : MISS;
          m_vld[b] = 1'b1; m_row[b] = r;
          pend_v[b] = 1'b1; pend_at[b] = cyc + lat; ready[b] = cyc + lat + 1;
          last_iss = cyc;
          eidx++;
        end
      end
      for (int k = 0; k < 2; k++) begin
        done_x = pend_v[k] && (cyc == pend_at[k]);
        busy_x = pend_v[k] && (cyc < pend_at[k]);
        if (done_x || bank_done[k]) chk(bank_done[k] == done_x, "R6 bank_done", int'(bank_done[k]), int'(done_x));
        if (bank_busy[k] != busy_x) chk(1'b0, "R6 bank_busy", int'(bank_busy[k]), int'(busy_x));
        if (pend_v[k] && cyc >= pend_at[k]) pend_v[k] = 1'b0;
      end
      if (head_pop) idx++;
      head_valid = (idx < nq);
      if (idx < nq) head_addr = q[idx];
      if (idx >= nq && eidx >= nq && !pend_v[0] && !pend_v[1]) finished = 1'b1;
    end
    head_valid = 1'b0;
    repeat (3) step();
    chk(bank_done == 2'b00 && issue_valid == 1'b0, "R6 quiet after phase", int'(bank_done), 0);
  endtask

  initial begin
    void'($urandom(32'd4321));
    // directed: decode, hit/miss, row update, first miss per bank, max row
    do_reset();
    nq = 7;
    q[0] = mk(5, 0, 3, 9);         // miss (cold) R8
    q[1] = mk(5, 0, 63, 63);       // hit, offset ignored R1
    q[2] = mk(5, 1, 0, 0);         // miss, first on bank 1
    q[3] = mk(16383, 0, 17, 1);    // miss, all-ones row
    q[4] = mk(5, 0, 2, 0);         // miss, row changed R7
    q[5] = mk(5, 1, 40, 7);        // hit on bank 1
    q[6] = mk(16383, 0, 0, 0);     // miss, open row now 5
    run_phase("directed rows");
    // directed: head blocked while other bank idle R3
    do_reset();
    nq = 4;
    q[0] = mk(1, 0, 0, 0);
    q[1] = mk(2, 0, 0, 0);
    q[2] = mk(1, 1, 5, 0);
    q[3] = mk(1, 1, 6, 0);
    run_phase("head blocking");
    // random mix with small row set for frequent hits
    do_reset();
    nq = 150;
    for (int i = 0; i < 150; i++) begin
      int rr;
      rr = ($urandom % 8 == 0) ? int'($urandom % 16384) : int'($urandom % 3);
      q[i] = mk(rr, int'($urandom % 2), int'($urandom % 64), int'($urandom % 64));
    end
    run_phase("random");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog global actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule